// File: doc/BRIEF.md
# Analog Input Scan Sequencer

This block decides which analog input the converter measures on each conversion. It holds a small piece of state: the current scan position and which of two input selections is active. It then drives the positive and negative select codes for the analog multiplexer. The block moves only when the converter reports a finished conversion. A start pulse puts it back at the beginning of a sequence.

Two selections exist: primary (A) and secondary (B). Each gives a positive input code and a negative reference code for unipolar differential measurement. Four modes are available:
- Fixed mode repeats the A selection.
- Alternate mode swaps between A and B on every sweep.
- Scan mode visits the set bits of a 32-bit input bitmap in ascending order. Scanning only ever uses A.
- Scan-alternate mode does a full A scan, then one conversion on B, then repeats.

A one-cycle flag marks the end of each sweep. A level flag reports a scan with an empty bitmap.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `sel_b_o` and `sweep_end_o` are 0. In scan mode, before any start pulse, `pos_sel_o` is 0.
- R2: In fixed mode (`mode_i`=0), `pos_sel_o`/`neg_sel_o` equal the A codes and `sel_b_o` is 0. Each conversion-done pulse raises `sweep_end_o` in the following cycle.
- R3: Without a conversion-done or start pulse, and with the mode and bitmap held, the selection does not change.
- R4: In scan mode (`mode_i`=2), a start pulse selects the lowest set bit of `scan_map_i`. Each conversion-done pulse moves to the next higher set bit. Bitmap 0x1A gives 1, 3, 4.
- R5: A done pulse on the highest set bit wraps to the lowest set bit. `sweep_end_o` is high for exactly the next cycle. This includes bitmaps using bits 0 and 31.
- R6: In scan mode `neg_sel_o` equals the A negative code and `sel_b_o` stays 0.
- R7: In alternate mode (`mode_i`=1), each done pulse toggles between the A and B codes. `sel_b_o` shows 1 while B is selected, and every done pulse ends a sweep.
- R8: In scan-alternate mode (`mode_i`=3), the block does one full ascending A scan, then one B conversion, then restarts the A scan. `sweep_end_o` pulses after the last A input and after the B conversion.
- R9: In a scan mode with an all-zero bitmap, `cfg_err_o` is 1 and the A-side selection stays on input 0. Done pulses neither move it nor signal a sweep end. Otherwise `cfg_err_o` is 0.
- R10: A start pulse returns to A and the lowest set bit. It wins over a simultaneous done pulse, and no sweep end is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 fixed, 1 alternate, 2 scan, 3 scan-alternate |
| scan_map_i | input | 32 | Inputs to visit in scan modes |
| a_pos_i | input | 5 | A positive input code |
| a_neg_i | input | NEG_W | A negative reference code |
| b_pos_i | input | 5 | B positive input code |
| b_neg_i | input | NEG_W | B negative reference code |
| start_i | input | 1 | Restart the sequence |
| conv_done_i | input | 1 | Conversion finished, advance |
| pos_sel_o | output | 5 | Current positive input code |
| neg_sel_o | output | NEG_W | Current negative reference code |
| sel_b_o | output | 1 | B selection active |
| sweep_end_o | output | 1 | One-cycle end-of-sweep flag |
| cfg_err_o | output | 1 | Scan requested with empty bitmap |

## Verification
The scan is driven with a sparse bitmap (0x1A) whose set bits are not adjacent. This shows ascending order and shows that cleared bits are skipped. A bitmap using only bits 0 and 31 covers the index range ends and the wrap. Alternate and scan-alternate runs tell a whole-sweep interleave apart from a per-conversion one, by where `sel_b_o` rises. An empty bitmap and a start pulse that coincides with a done pulse cover the error flag and the priority rule.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int SEQ_CH = 32;
    localparam int SEQ_IW = $clog2(SEQ_CH);

    typedef enum logic [1:0] {
        MODE_FIXED    = 2'd0,
        MODE_ALT      = 2'd1,
        MODE_SCAN     = 2'd2,
        MODE_SCAN_ALT = 2'd3
    } seq_mode_e;

    typedef struct packed {
        logic              on_b;
        logic [SEQ_IW-1:0] idx;
    } seq_state_t;

    function automatic logic is_scan(input seq_mode_e m);
        return (m == MODE_SCAN) || (m == MODE_SCAN_ALT);
    endfunction

    function automatic logic is_alt(input seq_mode_e m);
        return (m == MODE_ALT) || (m == MODE_SCAN_ALT);
    endfunction
endpackage

// File: rtl/adc_seq_lowbit.sv
module adc_seq_lowbit #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_mode_e         mode,
    input  logic              map_nz,
    input  logic [SEQ_IW-1:0] low_idx,
    input  logic              nxt_found,
    input  logic [SEQ_IW-1:0] nxt_idx,
    input  logic              start,
    input  logic              done,
    output seq_state_t        st,
    output logic              sweep_end
);
    seq_state_t st_n;
    logic       sw_n;
    logic [SEQ_IW-1:0] first_idx;

    assign first_idx = map_nz ? low_idx : '0;

    always_comb begin
        st_n = st;
        sw_n = 1'b0;
        if (start) begin
            st_n.on_b = 1'b0;
            st_n.idx  = first_idx;
        end else if (done) begin
            unique case (mode)
                MODE_FIXED: sw_n = 1'b1;
                MODE_ALT: begin
                    st_n.on_b = ~st.on_b;
                    sw_n      = 1'b1;
                end
                MODE_SCAN: begin
                    st_n.on_b = 1'b0;
                    if (map_nz) begin
                        if (nxt_found) begin
                            st_n.idx = nxt_idx;
                        end else begin
                            st_n.idx = low_idx;
                            sw_n     = 1'b1;
                        end
                    end
                end
                MODE_SCAN_ALT: begin
                    if (st.on_b) begin
                        st_n.on_b = 1'b0;
                        st_n.idx  = first_idx;
                        sw_n      = 1'b1;
                    end else if (map_nz) begin
                        if (nxt_found) begin
                            st_n.idx = nxt_idx;
                        end else begin
                            st_n.on_b = 1'b1;
                            sw_n      = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            sweep_end <= 1'b0;
        end else begin
            st        <= st_n;
            sweep_end <= sw_n;
        end
    end
endmodule

// File: rtl/adc_seq_outmux.sv
module adc_seq_outmux
    import adc_seq_pkg::*;
#(
    parameter int NEG_W = 2
) (
    input  seq_mode_e         mode,
    input  seq_state_t        st,
    input  logic              map_nz,
    input  logic [SEQ_IW-1:0] a_pos,
    input  logic [NEG_W-1:0]  a_neg,
    input  logic [SEQ_IW-1:0] b_pos,
    input  logic [NEG_W-1:0]  b_neg,
    output logic [SEQ_IW-1:0] pos_sel,
    output logic [NEG_W-1:0]  neg_sel,
    output logic              sel_b,
    output logic              cfg_err
);
    always_comb begin
        sel_b   = is_alt(mode) && st.on_b;
        cfg_err = is_scan(mode) && !map_nz;
        if (sel_b) begin
            pos_sel = b_pos;
            neg_sel = b_neg;
        end else if (is_scan(mode)) begin
            pos_sel = map_nz ? st.idx : '0;
            neg_sel = a_neg;
        end else begin
            pos_sel = a_pos;
            neg_sel = a_neg;
        end
    end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NEG_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode_i,
    input  logic [SEQ_CH-1:0]   scan_map_i,
    input  logic [SEQ_IW-1:0]   a_pos_i,
    input  logic [NEG_W-1:0]    a_neg_i,
    input  logic [SEQ_IW-1:0]   b_pos_i,
    input  logic [NEG_W-1:0]    b_neg_i,
    input  logic                start_i,
    input  logic                conv_done_i,
    output logic [SEQ_IW-1:0]   pos_sel_o,
    output logic [NEG_W-1:0]    neg_sel_o,
    output logic                sel_b_o,
    output logic                sweep_end_o,
    output logic                cfg_err_o
);
    seq_mode_e         mode;
    seq_state_t        st;
    logic [SEQ_CH-1:0] above;
    logic              low_found, nxt_found;
    logic [SEQ_IW-1:0] low_idx, nxt_idx;

    assign mode = seq_mode_e'(mode_i);

    // Bits strictly above the current scan position
    for (genvar g = 0; g < SEQ_CH; g++) begin : g_above
        assign above[g] = scan_map_i[g] && (SEQ_IW'(g) > st.idx);
    end

    adc_seq_lowbit #(.W(SEQ_CH)) u_low (
        .vec_i(scan_map_i), .found_o(low_found), .idx_o(low_idx)
    );

    adc_seq_lowbit #(.W(SEQ_CH)) u_next (
        .vec_i(above), .found_o(nxt_found), .idx_o(nxt_idx)
    );

    adc_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .mode(mode), .map_nz(low_found),
        .low_idx(low_idx), .nxt_found(nxt_found), .nxt_idx(nxt_idx),
        .start(start_i), .done(conv_done_i), .st(st), .sweep_end(sweep_end_o)
    );

    adc_seq_outmux #(.NEG_W(NEG_W)) u_mux (
        .mode(mode), .st(st), .map_nz(low_found),
        .a_pos(a_pos_i), .a_neg(a_neg_i), .b_pos(b_pos_i), .b_neg(b_neg_i),
        .pos_sel(pos_sel_o), .neg_sel(neg_sel_o), .sel_b(sel_b_o),
        .cfg_err(cfg_err_o)
    );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int NEG_W = 2
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode_i,
    input logic [SEQ_CH-1:0]   scan_map_i,
    input logic [SEQ_IW-1:0]   a_pos_i,
    input logic [NEG_W-1:0]    a_neg_i,
    input logic [SEQ_IW-1:0]   b_pos_i,
    input logic [NEG_W-1:0]    b_neg_i,
    input logic                start_i,
    input logic                conv_done_i,
    input logic [SEQ_IW-1:0]   pos_sel_o,
    input logic [NEG_W-1:0]    neg_sel_o,
    input logic                sel_b_o,
    input logic                sweep_end_o,
    input logic                cfg_err_o
);
    AST_FIXED_USES_A: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'd0 |-> !sel_b_o && pos_sel_o == a_pos_i && neg_sel_o == a_neg_i); // R2

    AST_SCAN_ONLY_A: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'd2 |-> !sel_b_o && neg_sel_o == a_neg_i); // R6

    AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd2 && !conv_done_i && !start_i) |=>
        (mode_i != $past(mode_i) || scan_map_i != $past(scan_map_i) || $stable(pos_sel_o))); // R3

    AST_SWEEP_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        sweep_end_o |-> $past(conv_done_i) && !$past(start_i)); // R5

    AST_EMPTY_MAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_err_o && !sel_b_o) |-> pos_sel_o == '0); // R9

    AST_ALT_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'd1 && $past(mode_i) == 2'd1 && $past(conv_done_i) &&
         !$past(start_i) && !$past(rst)) |-> sel_b_o != $past(sel_b_o)); // R7
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NEG_W(NEG_W)) u_chk (.*);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 17;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] map;
        logic        st;
        logic        dn;
        logic [4:0]  pos;
        logic [1:0]  neg;
        logic        ub;
        logic        sw;
    } vec_t;

    // A codes: pos 7 neg 1; B codes: pos 20 neg 2
    localparam vec_t VECS [NV] = '{
        '{2'd2, 32'h1A, 1'b1, 1'b0, 5'd1,  2'd1, 1'b0, 1'b0}, // R4 start -> lowest
        '{2'd2, 32'h1A, 1'b0, 1'b1, 5'd3,  2'd1, 1'b0, 1'b0}, // R4
        '{2'd2, 32'h1A, 1'b0, 1'b0, 5'd3,  2'd1, 1'b0, 1'b0}, // R3 hold
        '{2'd2, 32'h1A, 1'b0, 1'b1, 5'd4,  2'd1, 1'b0, 1'b0}, // R4 R6
        '{2'd2, 32'h1A, 1'b0, 1'b1, 5'd1,  2'd1, 1'b0, 1'b1}, // R5 wrap
        '{2'd2, 32'h1A, 1'b0, 1'b0, 5'd1,  2'd1, 1'b0, 1'b0}, // R5 one cycle
        '{2'd1, 32'h1A, 1'b1, 1'b0, 5'd7,  2'd1, 1'b0, 1'b0}, // R7 start on A
        '{2'd1, 32'h1A, 1'b0, 1'b1, 5'd20, 2'd2, 1'b1, 1'b1}, // R7 to B
        '{2'd1, 32'h1A, 1'b0, 1'b0, 5'd20, 2'd2, 1'b1, 1'b0}, // R7 R3 hold
        '{2'd1, 32'h1A, 1'b0, 1'b1, 5'd7,  2'd1, 1'b0, 1'b1}, // R7 back to A
        '{2'd3, 32'h1A, 1'b1, 1'b0, 5'd1,  2'd1, 1'b0, 1'b0}, // R8
        '{2'd3, 32'h1A, 1'b0, 1'b1, 5'd3,  2'd1, 1'b0, 1'b0}, // R8
        '{2'd3, 32'h1A, 1'b0, 1'b1, 5'd4,  2'd1, 1'b0, 1'b0}, // R8
        '{2'd3, 32'h1A, 1'b0, 1'b1, 5'd20, 2'd2, 1'b1, 1'b1}, // R8 B after scan
        '{2'd3, 32'h1A, 1'b0, 1'b1, 5'd1,  2'd1, 1'b0, 1'b1}, // R8 scan restarts
        '{2'd0, 32'h1A, 1'b1, 1'b0, 5'd7,  2'd1, 1'b0, 1'b0}, // R2
        '{2'd0, 32'h1A, 1'b0, 1'b1, 5'd7,  2'd1, 1'b0, 1'b1}  // R2 sweep per done
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_i;
    logic [31:0] scan_map_i;
    logic [4:0]  a_pos_i, b_pos_i;
    logic [1:0]  a_neg_i, b_neg_i;
    logic        start_i, conv_done_i;
    logic [4:0]  pos_sel_o;
    logic [1:0]  neg_sel_o;
    logic        sel_b_o, sweep_end_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_scan_seq uut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .scan_map_i(scan_map_i),
        .a_pos_i(a_pos_i), .a_neg_i(a_neg_i), .b_pos_i(b_pos_i), .b_neg_i(b_neg_i),
        .start_i(start_i), .conv_done_i(conv_done_i),
        .pos_sel_o(pos_sel_o), .neg_sel_o(neg_sel_o), .sel_b_o(sel_b_o),
        .sweep_end_o(sweep_end_o), .cfg_err_o(cfg_err_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive for one cycle at the falling edge, outputs settle after the next rising edge
    task automatic step(input logic [1:0] m, input logic [31:0] map, input logic s, input logic d);
        mode_i = m; scan_map_i = map; start_i = s; conv_done_i = d;
        @(negedge clk);
        start_i = 1'b0; conv_done_i = 1'b0;
    endtask

    initial begin
        rst = 1'b1; mode_i = 2'd2; scan_map_i = 32'h1A;
        a_pos_i = 5'd7; a_neg_i = 2'd1; b_pos_i = 5'd20; b_neg_i = 2'd2;
        start_i = 1'b0; conv_done_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pos", pos_sel_o, 0);
        chk("R1", "sel_b", sel_b_o, 0);
        chk("R1", "sweep", sweep_end_o, 0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].mode, VECS[i].map, VECS[i].st, VECS[i].dn);
            chk($sformatf("R vec%0d", i), "pos", pos_sel_o, VECS[i].pos);
            chk($sformatf("R vec%0d", i), "neg", neg_sel_o, VECS[i].neg);
            chk($sformatf("R vec%0d", i), "sel_b", sel_b_o, VECS[i].ub);
            chk($sformatf("R vec%0d", i), "sweep", sweep_end_o, VECS[i].sw);
            chk("R9", "cfg_err", cfg_err_o, 0);
        end

        // R9: empty bitmap
        step(2'd2, 32'h0, 1'b1, 1'b0);
        chk("R9", "cfg_err", cfg_err_o, 1);
        chk("R9", "pos", pos_sel_o, 0);
        step(2'd2, 32'h0, 1'b0, 1'b1);
        chk("R9", "pos after done", pos_sel_o, 0);
        chk("R9", "sweep", sweep_end_o, 0);

        // R5: bits 0 and 31
        step(2'd2, 32'h8000_0001, 1'b1, 1'b0);
        chk("R5", "pos low end", pos_sel_o, 0);
        step(2'd2, 32'h8000_0001, 1'b0, 1'b1);
        chk("R5", "pos high end", pos_sel_o, 31);
        chk("R5", "sweep", sweep_end_o, 0);
        step(2'd2, 32'h8000_0001, 1'b0, 1'b1);
        chk("R5", "pos wrap", pos_sel_o, 0);
        chk("R5", "sweep", sweep_end_o, 1);

        // R10: start wins over done
        step(2'd2, 32'h1A, 1'b1, 1'b0);
        step(2'd2, 32'h1A, 1'b0, 1'b1);
        chk("R10", "pos before", pos_sel_o, 3);
        step(2'd2, 32'h1A, 1'b1, 1'b1);
        chk("R10", "pos", pos_sel_o, 1);
        chk("R10", "sweep", sweep_end_o, 0);

        // R10: start while on B returns to A
        step(2'd1, 32'h1A, 1'b1, 1'b0);
        step(2'd1, 32'h1A, 1'b0, 1'b1);
        step(2'd1, 32'h1A, 1'b1, 1'b0);
        chk("R10", "sel_b", sel_b_o, 0);

        // R2: fixed mode follows A codes directly
        a_pos_i = 5'd12;
        step(2'd0, 32'h1A, 1'b0, 1'b0);
        chk("R2", "pos", pos_sel_o, 12);

        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule